// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port with Programmable Bit Rate

This block is a full-duplex asynchronous serial port for a peripheral subsystem. Its transmit path and its receive path each have a 16-entry first-in first-out queue, a separate enable and a separate level-triggered interrupt output. A 16-bit divisor, written as two bytes, sets the bit rate from the block clock. A frame register selects the character length (1 to 8 bits), optional even or odd parity, one or two stop bits and an internal loopback of the transmit line into the receiver.

Software uses a small register bus. Writes program the divisor, frame format, control bits, transmit data and the two interrupt thresholds. Reads return received characters, both fill counts and the status flags. After reset the serial engines are held idle and both queues are held empty. Software sets separate run bits to release them. The receiver takes eight samples per bit and decides each bit by a majority of the three middle samples. It drops a start bit that does not stay low up to mid-bit.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset `ser_tx` is 1 and both interrupts are 0. The level register (address 5) reads 0x1F00: transmit level in bits [7:0] is 0, receive level in bits [15:8] is all ones in its 5 bits. The count register (address 6) reads 0. The flags register (address 7) reads 0: bit0 is transmit-ready, bit1 is transmit overflow, bit2 is receive overrun. While a queue's run bit is 0 the queue is empty and writes to it are lost.
- R2: The divisor D is {address 0 byte, address 1 byte}. For D from 1 to 65535 each serial bit lasts 8*(D+1) clocks. For D = 0 each bit lasts 16 clocks.
- R3: Frame register (address 2): bits [2:0] are the length minus 1, bit3 enables parity, bit4 selects even parity (0 selects odd), bit5 selects two stop bits, bit6 enables loopback. The value 7 gives 8 data bits, no parity, one stop bit and no loopback. A frame is one low start bit, then the data bits LSB first, then the parity bit if enabled, then one or two high stop bits.
- R4: Characters written to address 4 leave in write order. A write while the transmit queue holds 16 characters is dropped and sets flag bit1. Flag bit0 reads 1 exactly when the transmit queue is running and not full. Writing 1 to flag bit1 or bit2 clears that flag.
- R5: The receiver samples at 8 times the bit rate and sets each bit to the majority of samples 3, 4 and 5. A glitch two clocks wide inside a bit does not change the received character.
- R6: A low pulse on `ser_rx` that ends before mid-bit is not taken as a start bit and stores nothing.
- R7: A character received while the receive queue holds 16 is discarded and sets flag bit2. The stored 16 characters are kept and read out from address 4 in arrival order. Each read from address 4 removes one character.
- R8: `irq_rx` is 1 when the receive interrupt enable (control bit6) is set and the receive count is greater than or equal to the receive level. With the reset level, 16 stored characters do not raise it.
- R9: `irq_tx` is 1 when the transmit interrupt enable (control bit5) is set and the transmit count is less than or equal to the transmit level.
- R10: With loopback set, the receiver takes its input from the transmit line, and a written character is read back from the receive queue.
- R11: Control bit0 enables transmission and bit1 enables reception. While transmission is disabled, queued characters stay queued. While reception is disabled, frames on `ser_rx` store nothing.
- R12: Until control bit2 is set, both serial engines are held idle and `ser_tx` stays 1. Control bits 3 and 4 release the transmit and receive queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the bit-rate reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 4 removes a character |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the address |
| ser_rx | input | 1 | Serial input line |
| ser_tx | output | 1 | Serial output line, idle high |
| irq_tx | output | 1 | Transmit queue level interrupt |
| irq_rx | output | 1 | Receive queue level interrupt |

## Verification
The bench builds the block with its default parameters: 16-entry queues, 5-bit levels and a two-stage input synchronizer. With these defaults both the 16-entry overflow and overrun edges and the reset receive level of 31, which no fill count can reach, are exercised. At run time it programs divisor 2, which gives 24-clock bits, and briefly divisor 0, so that the special 16-clock case is measured directly. Frame formats of 8N1, 7E2 and 7O2 are used, and the loopback path is tested.

// File: rtl/uart_pkg.sv
`timescale 1ns/1ps
package uart_pkg;
   localparam int BUS_W = 16;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_FRAME  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA   = 3'd4;
   localparam logic [ADDR_W-1:0] A_LEVEL  = 3'd5;
   localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;
   localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd7;

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ser_st_e;

   // packed so that the field order matches the frame register bits 6..0
   typedef struct packed {
      logic       loopback;
      logic       two_stop;
      logic       par_even;
      logic       par_en;
      logic [2:0] len_m1;
   } frame_cfg_t;

   // packed so that the field order matches the control register bits 6..0
   typedef struct packed {
      logic rx_ie;
      logic tx_ie;
      logic rxf_run;
      logic txf_run;
      logic run;
      logic rx_en;
      logic tx_en;
   } ctrl_t;
endpackage

// File: rtl/uart_baud_gen.sv
`timescale 1ns/1ps
module uart_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   // sample period is divisor+1 clocks, except that zero means two clocks
   assign last = (divisor == '0) ? CW'(1) : {1'b0, divisor};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!run) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= last) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/uart_fifo.sv
`timescale 1ns/1ps
module uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   assert_full_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);
endmodule

// File: rtl/uart_tx_eng.sv
`timescale 1ns/1ps
module uart_tx_eng
   import uart_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  frame_cfg_t cfg,
   input  logic       avail_i,
   input  logic [7:0] data_i,
   output logic       pop_o,
   output logic       line_o
);
   ser_st_e    st;
   logic [2:0] s, bitn;
   logic [7:0] sh, masked;
   logic       par, stop2;

   assign masked = data_i & (8'hFF >> (3'd7 - cfg.len_m1));
   assign pop_o  = en && tick && (st == S_IDLE) && avail_i;

   always_comb begin
      unique case (st)
         S_START: line_o = 1'b0;
         S_DATA:  line_o = sh[0];
         S_PAR:   line_o = par;
         default: line_o = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; s <= '0; bitn <= '0; sh <= '0; par <= 1'b0; stop2 <= 1'b0;
      end else if (!en) begin
         st <= S_IDLE;
         s  <= '0;
      end else if (tick) begin
         if (st == S_IDLE) begin
            if (avail_i) begin
               st  <= S_START;
               s   <= '0;
               sh  <= masked;
               par <= cfg.par_even ? ^masked : ~^masked;
            end
         end else begin
            s <= s + 1'b1;
            if (s == 3'd7) begin
               unique case (st)
                  S_START: begin
                     st   <= S_DATA;
                     bitn <= '0;
                  end
                  S_DATA: begin
                     sh <= sh >> 1;
                     if (bitn == cfg.len_m1) begin
                        st    <= cfg.par_en ? S_PAR : S_STOP;
                        stop2 <= cfg.two_stop;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end
                  S_PAR: begin
                     st    <= S_STOP;
                     stop2 <= cfg.two_stop;
                  end
                  default: begin
                     if (stop2) stop2 <= 1'b0;
                     else       st    <= S_IDLE;
                  end
               endcase
            end
         end
      end
   end

   assert_line_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> line_o);
endmodule

// File: rtl/uart_rx_eng.sv
`timescale 1ns/1ps
module uart_rx_eng
   import uart_pkg::*;
#(
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  frame_cfg_t cfg,
   input  logic       rx_i,
   input  logic       loop_i,
   output logic       push_o,
   output logic [7:0] data_o
);
   if (SYNC < 1) begin : g_bad_sync
      $error("uart_rx_eng: SYNC must be at least 1");
   end

   logic synced;

   if (SYNC == 1) begin : g_sync1
      logic q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= 1'b1; else q <= rx_i;
      assign synced = q;
   end else begin : g_syncn
      logic [SYNC-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= '1; else q <= {q[SYNC-2:0], rx_i};
      assign synced = q[SYNC-1];
   end

   ser_st_e    st;
   logic [2:0] s, bitn;
   logic [7:0] sh;
   logic       a, b, line, maj;

   assign line = cfg.loopback ? loop_i : synced;
   assign maj  = (a & b) | (a & line) | (b & line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; s <= '0; bitn <= '0; sh <= '0;
         a <= 1'b1; b <= 1'b1; push_o <= 1'b0; data_o <= '0;
      end else begin
         push_o <= 1'b0;
         if (!en) begin
            st <= S_IDLE;
            s  <= '0;
         end else if (tick) begin
            s <= s + 1'b1;
            if (s == 3'd3) a <= line;
            if (s == 3'd4) b <= line;
            unique case (st)
               S_IDLE: begin
                  s <= '0;
                  if (!line) begin
                     st <= S_START;
                     s  <= 3'd1;
                  end
               end
               S_START: begin
                  if ((s <= 3'd4 && line) || (s == 3'd5 && maj)) begin
                     st <= S_IDLE;
                     s  <= '0;
                  end else if (s == 3'd7) begin
                     st   <= S_DATA;
                     bitn <= '0;
                  end
               end
               S_DATA: begin
                  if (s == 3'd5) sh <= {maj, sh[7:1]};
                  if (s == 3'd7) begin
                     if (bitn == cfg.len_m1) st <= cfg.par_en ? S_PAR : S_STOP;
                     else                    bitn <= bitn + 1'b1;
                  end
               end
               S_PAR: begin
                  if (s == 3'd7) st <= S_STOP;
               end
               default: begin
                  if (s == 3'd5) begin
                     push_o <= 1'b1;
                     data_o <= sh >> (3'd7 - cfg.len_m1);
                     st     <= S_IDLE;
                     s      <= '0;
                  end
               end
            endcase
         end
      end
   end

   assert_push_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> $past(tick));
endmodule

// File: rtl/uart_fifo_core.sv
`timescale 1ns/1ps
module uart_fifo_core
   import uart_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5,
   parameter int SYNC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              ser_rx,
   output logic              ser_tx,
   output logic              irq_tx,
   output logic              irq_rx
);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int DIV_W = 16;

   if (CNT_W > 8 || LVL_W > 8 || LVL_W < 1) begin : g_bad_width
      $error("uart_fifo_core: counts and levels must fit in 8 bits");
   end

   logic [7:0]       div_hi, div_lo;
   frame_cfg_t       cfg;
   ctrl_t            ctl;
   logic [LVL_W-1:0] tx_lvl, rx_lvl;
   logic             tx_ovf, rx_ovr;
   logic             tick;

   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic [7:0]       tx_head;
   logic [CNT_W-1:0] tx_cnt;
   logic             rx_pop, rx_full, rx_empty, rx_got;
   logic [7:0]       rx_head, rx_char;
   logic [CNT_W-1:0] rx_cnt;
   logic             tx_line;

   wire unused_wdata = ^bus_wdata;

   assign tx_push = bus_wr && (bus_addr == A_DATA) && ctl.txf_run;
   assign rx_pop  = bus_rd && (bus_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_hi <= '0;
         div_lo <= '0;
         cfg    <= '0;
         ctl    <= '0;
         tx_lvl <= '0;
         rx_lvl <= '1;
         tx_ovf <= 1'b0;
         rx_ovr <= 1'b0;
      end else begin
         if (bus_wr) begin
            unique case (bus_addr)
               A_DIV_HI: div_hi <= bus_wdata[7:0];
               A_DIV_LO: div_lo <= bus_wdata[7:0];
               A_FRAME:  cfg    <= bus_wdata[6:0];
               A_CTRL:   ctl    <= bus_wdata[6:0];
               A_LEVEL: begin
                  tx_lvl <= bus_wdata[LVL_W-1:0];
                  rx_lvl <= bus_wdata[8+LVL_W-1:8];
               end
               A_FLAGS: begin
                  if (bus_wdata[1]) tx_ovf <= 1'b0;
                  if (bus_wdata[2]) rx_ovr <= 1'b0;
               end
               default: ;
            endcase
         end
         if (tx_push && tx_full)                 tx_ovf <= 1'b1;
         if (rx_got && ctl.rxf_run && rx_full)   rx_ovr <= 1'b1;
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_DIV_HI: bus_rdata = {8'h00, div_hi};
         A_DIV_LO: bus_rdata = {8'h00, div_lo};
         A_FRAME:  bus_rdata = BUS_W'(cfg);
         A_CTRL:   bus_rdata = BUS_W'(ctl);
         A_DATA:   bus_rdata = {8'h00, rx_head};
         A_LEVEL:  bus_rdata = {8'(rx_lvl), 8'(tx_lvl)};
         A_COUNT:  bus_rdata = {8'(rx_cnt), 8'(tx_cnt)};
         default:  bus_rdata = {13'h0, rx_ovr, tx_ovf, ctl.txf_run && !tx_full};
      endcase
   end

   assign irq_tx = ctl.tx_ie && ctl.txf_run && (8'(tx_cnt) <= 8'(tx_lvl));
   assign irq_rx = ctl.rx_ie && ctl.rxf_run && (8'(rx_cnt) >= 8'(rx_lvl));

   uart_baud_gen #(.DIV_W(DIV_W)) i_baud (
      .clk(clk), .rst_n(rst_n), .run(ctl.run),
      .divisor({div_hi, div_lo}), .tick(tick)
   );

   uart_fifo #(.W(8), .DEPTH(DEPTH)) i_txq (
      .clk(clk), .rst_n(rst_n), .clr(!ctl.txf_run),
      .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
      .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   uart_fifo #(.W(8), .DEPTH(DEPTH)) i_rxq (
      .clk(clk), .rst_n(rst_n), .clr(!ctl.rxf_run),
      .push(rx_got), .din(rx_char), .pop(rx_pop),
      .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   uart_tx_eng i_tx (
      .clk(clk), .rst_n(rst_n), .en(ctl.run && ctl.tx_en), .tick(tick),
      .cfg(cfg), .avail_i(!tx_empty), .data_i(tx_head),
      .pop_o(tx_pop), .line_o(tx_line)
   );

   uart_rx_eng #(.SYNC(SYNC)) i_rx (
      .clk(clk), .rst_n(rst_n), .en(ctl.run && ctl.rx_en), .tick(tick),
      .cfg(cfg), .rx_i(ser_rx), .loop_i(tx_line),
      .push_o(rx_got), .data_o(rx_char)
   );

   assign ser_tx = tx_line;

   assert_tx_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && tx_full) |=> tx_ovf);
   assert_rx_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_got && ctl.rxf_run && rx_full) |=> rx_ovr);
   assert_rx_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_pop && ctl.rxf_run) |=> rx_full);
   assert_idle_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.run && $past(!ctl.run)) |-> ser_tx);
   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> (!irq_rx || rx_lvl == '0));
endmodule

// File: tb/test_uart_fifo_core.sv
`timescale 1ns/1ps
module test_uart_fifo_core;
   import uart_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ser_rx = 1'b1;
   logic        ser_tx, irq_tx, irq_rx;

   always #2.5 clk = ~clk;  // 200 MHz

   uart_fifo_core i_uart_fifo_core (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   int checks = 0, errors = 0, frames = 0;
   int bp = 24;
   int m_len = 8;
   bit m_par = 0, m_even = 0, m_stop2 = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bwrite(logic [2:0] a, logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bread(logic [2:0] a, output logic [15:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   function automatic logic par_of(logic [7:0] v);
      logic [7:0] m;
      m = v & (8'hFF >> (8 - m_len));
      return m_even ? ^m : ~^m;
   endfunction

   task automatic drv(logic b, bit glitch);
      ser_rx = b;
      if (glitch) begin
         repeat (12) @(negedge clk); ser_rx = ~b;
         repeat (2)  @(negedge clk); ser_rx = b;
         repeat (bp - 14) @(negedge clk);
      end else begin
         repeat (bp) @(negedge clk);
      end
   endtask

   // scoreboard driver for the receive side: frame on ser_rx
   task automatic rx_send(logic [7:0] v, int gbit, bit expect_it);
      if (expect_it) rxq.push_back(v & (8'hFF >> (8 - m_len)));
      @(negedge clk);
      drv(1'b0, 0);
      for (int i = 0; i < m_len; i++) drv(v[i], i == gbit);
      if (m_par) drv(par_of(v), 0);
      drv(1'b1, 0);
      if (m_stop2) drv(1'b1, 0);
   endtask

   task automatic tx_send(logic [7:0] v, bit expect_it);
      if (expect_it) txq.push_back(v & (8'hFF >> (8 - m_len)));
      bwrite(A_DATA, {8'h00, v});
   endtask

   task automatic drain();
      wait (txq.size() == 0);
      repeat (3 * bp) @(negedge clk);
   endtask

   task automatic rx_check(string tag);
      logic [15:0] d;
      bread(A_DATA, d);
      check(tag, d[7:0], rxq.pop_front());
   endtask

   task automatic poll_tx_count(int target, int irq_exp);
      @(negedge clk); bus_addr = A_COUNT; bus_rd = 1'b1;
      forever begin
         #1;
         if (bus_rdata[7:0] == 8'(target)) break;
         @(negedge clk);
      end
      check("R9 irq_tx vs level", irq_tx, irq_exp);
      @(negedge clk); bus_rd = 1'b0;
   endtask

   // scoreboard monitor: decodes frames on ser_tx and compares
   initial begin
      logic [7:0] v;
      forever begin
         @(negedge ser_tx);
         repeat (bp / 2) @(negedge clk);
         check("R3 start bit low", ser_tx, 0);
         v = '0;
         for (int i = 0; i < m_len; i++) begin
            repeat (bp) @(negedge clk);
            v[i] = ser_tx;
         end
         if (m_par) begin
            repeat (bp) @(negedge clk);
            check("R3 parity bit", ser_tx, par_of(v));
         end
         repeat (bp) @(negedge clk);
         check("R3 stop bit", ser_tx, 1);
         if (m_stop2) begin
            repeat (bp) @(negedge clk);
            check("R3 second stop bit", ser_tx, 1);
         end
         frames++;
         if (txq.size() == 0) check("R4 unexpected frame", v, -1);
         else                 check("R4 frame data in order", v, txq.pop_front());
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 ser_tx idle", ser_tx, 1);
      check("R1 irq_tx", irq_tx, 0);
      check("R1 irq_rx", irq_rx, 0);
      bread(A_LEVEL, d); check("R1 level reset", d, 16'h1F00);
      bread(A_FLAGS, d); check("R1 flags reset", d, 0);
      bwrite(A_DATA, 16'h0077);
      bread(A_COUNT, d); check("R1 held queue drops write", d, 0);

      bwrite(A_DIV_HI, 16'h0000);
      bwrite(A_DIV_LO, 16'h0002);
      bwrite(A_FRAME, 16'h0007);
      bp = 24;

      // R12 engines held until run bit
      bwrite(A_CTRL, 16'h0009);
      tx_send(8'h55, 1);
      bread(A_COUNT, d); check("R12 queued while held", d, 16'h0001);
      bread(A_FLAGS, d); check("R4 tx ready when not full", d, 16'h0001);
      repeat (400) @(negedge clk);
      bread(A_COUNT, d); check("R12 nothing sent while held", d, 16'h0001);
      check("R12 line high while held", ser_tx, 1);
      bwrite(A_CTRL, 16'h000D);
      drain();
      check("R12 frame after release", frames, 1);

      // R2 bit length
      tx_send(8'h01, 1);
      @(negedge ser_tx); n = 0;
      while (ser_tx == 1'b0) begin @(posedge clk); #1; n++; end
      check("R2 bit length divisor 2", n, 24);
      drain();
      bwrite(A_DIV_LO, 16'h0000); bp = 16;
      tx_send(8'h01, 1);
      @(negedge ser_tx); n = 0;
      while (ser_tx == 1'b0) begin @(posedge clk); #1; n++; end
      check("R2 bit length divisor 0", n, 16);
      drain();
      bwrite(A_DIV_LO, 16'h0002); bp = 24;

      // R4 ordering, 8N1
      tx_send(8'h12, 1); tx_send(8'h34, 1); tx_send(8'hAB, 1);
      tx_send(8'hFE, 1); tx_send(8'h80, 1);
      drain();
      check("R4 frame count", frames, 8);

      // R3 7E2 and 7O2
      bwrite(A_FRAME, 16'h003E); m_len = 7; m_par = 1; m_even = 1; m_stop2 = 1;
      tx_send(8'h35, 1); tx_send(8'h6C, 1);
      drain();
      bwrite(A_FRAME, 16'h002E); m_even = 0;
      tx_send(8'h35, 1);
      drain();
      bwrite(A_FRAME, 16'h0007); m_len = 8; m_par = 0; m_stop2 = 0;

      // R4 overflow, R9 level, R11 transmit disabled
      bwrite(A_LEVEL, 16'h1F04);
      bwrite(A_CTRL, 16'h002C);
      #1 check("R9 irq_tx with empty queue", irq_tx, 1);
      for (int i = 0; i < 17; i++) tx_send(8'(i * 7 + 3), i < 16);
      bread(A_COUNT, d); check("R4 count at full", d, 16'h0010);
      bread(A_FLAGS, d); check("R4 overflow set, not ready", d, 16'h0002);
      check("R9 irq_tx at full", irq_tx, 0);
      repeat (400) @(negedge clk);
      bread(A_COUNT, d); check("R11 queue kept while tx disabled", d, 16'h0010);
      bwrite(A_FLAGS, 16'h0002);
      bread(A_FLAGS, d); check("R4 overflow cleared", d, 16'h0000);
      bwrite(A_CTRL, 16'h002D);
      poll_tx_count(5, 0);
      poll_tx_count(4, 1);
      drain();

      // receive path, 8N1
      bwrite(A_CTRL, 16'h0056);
      rx_send(8'hA5, -1, 1);
      bread(A_COUNT, d); check("R5 rx count one", d, 16'h0100);
      check("R8 irq_rx at reset level", irq_rx, 0);
      rx_check("R5 rx data");
      rx_send(8'hFF, 3, 1);
      rx_check("R5 majority rejects low glitch");
      rx_send(8'h00, 5, 1);
      rx_check("R5 majority rejects high glitch");
      @(negedge clk); ser_rx = 1'b0;
      repeat (6) @(negedge clk); ser_rx = 1'b1;
      repeat (300) @(negedge clk);
      bread(A_COUNT, d); check("R6 short start rejected", d, 16'h0000);
      bwrite(A_FRAME, 16'h002E); m_len = 7; m_par = 1; m_even = 0; m_stop2 = 1;
      rx_send(8'h5A, -1, 1);
      rx_check("R3 rx 7O2 data");
      bwrite(A_FRAME, 16'h0007); m_len = 8; m_par = 0; m_stop2 = 0;

      // R7 overrun, R8 level
      bwrite(A_LEVEL, 16'h0204);
      rx_send(8'h40, -1, 1);
      check("R8 irq_rx below level", irq_rx, 0);
      rx_send(8'h41, -1, 1);
      check("R8 irq_rx at level", irq_rx, 1);
      for (int i = 2; i < 17; i++) rx_send(8'(8'h40 + i), -1, i < 16);
      bread(A_COUNT, d); check("R7 rx count at full", d, 16'h1000);
      bread(A_FLAGS, d); check("R7 overrun flag", d, 16'h0004);
      for (int i = 0; i < 16; i++) rx_check("R7 kept data in order");
      bwrite(A_FLAGS, 16'h0004);

      // R11 receive disabled
      bwrite(A_CTRL, 16'h0014);
      rx_send(8'h33, -1, 0);
      repeat (50) @(negedge clk);
      bread(A_COUNT, d); check("R11 rx disabled stores nothing", d, 16'h0000);

      // R10 loopback
      bwrite(A_FRAME, 16'h0047);
      bwrite(A_CTRL, 16'h001F);
      tx_send(8'h3C, 1);
      rxq.push_back(8'h3C);
      drain();
      rx_check("R10 loopback data");
      bread(A_COUNT, d); check("R10 rx queue empty after read", d, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule